// File: doc/BRIEF.md
# IP and L4 Header Exception Checker

This block classifies one received packet per strobe from a pre-parsed summary of its network and transport headers. An upstream parser supplies the IP version, the result of the IPv4 header checksum test, the TTL or hop limit, an options flag, the byte count actually captured, the IP header length and the IP total length. It also supplies the L4 protocol number, the L4 length, both port numbers, the TCP flag byte and the L4 checksum result. The checksum arithmetic and the byte-stream parsing are done elsewhere. This block only decides which exception applies.

For every strobe the block returns, one cycle later, a 3-bit IP exception code and a 4-bit L4 error code, together with a one-cycle valid pulse. Within each field the lowest-numbered non-zero code that applies is reported. The L4 checks run only when the IP result leaves the transport header meaningful. Downstream logic uses the two codes to route or drop the packet and to fill its work descriptor.

Top module: `hdr_exc_chk`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_vld` is 0 and `ip_code` and `l4_code` are 0 after that edge.
- R2: A high `sum_vld` at clock edge N gives `res_vld` = 1 after edge N, for exactly one cycle per strobe. While `res_vld` is 0, both code outputs are 0.
- R3: `ip_code` is 1 when `ip_ver` is neither 4 nor 6. It is 2 when `ip_ver` is 4 and `ip_csum_ok` is 0; the checksum flag is ignored for version 6. It is 3 when `cap_len` < `ip_hdr_len`.
- R4: `ip_code` is 4 when `cap_len` < `ip_tot_len`. It is 5 when `hop_lim` is 0. It is 6 when `ip_opt` is 1, which marks IPv4 options or early IPv6 extension headers.
- R5: When several IP conditions hold, `ip_code` is the lowest-numbered one. If none holds, it is 0.
- R6: L4 checks run only when the IP code is 0 or 6 and `l4_proto` is 6 (TCP) or 17 (UDP). Otherwise `l4_code` is 0.
- R7: `l4_code` is 1 when `cap_len` < `ip_hdr_len` plus the L4 header size (20 bytes for TCP, 8 bytes for UDP). It is 2 when `l4_csum_ok` is 0. It is 3 when `l4_len` differs from `ip_tot_len` minus `ip_hdr_len`. It is 4 when `src_port` or `dst_port` is 0.
- R8: For TCP, the flag bits are FIN = bit 0, SYN = bit 1, RST = bit 2 and URG = bit 5. `l4_code` is 8 when bits [5:0] are exactly FIN, 9 when bits [5:0] are all clear, 10 for FIN and RST, 11 for SYN and URG, 12 for SYN and RST, and 13 for SYN and FIN. Other bits may be in any state for codes 10 to 13.
- R9: The flag checks apply only to TCP. A UDP packet can raise only L4 codes 1 to 4, whatever its flag byte holds.
- R10: When several L4 conditions hold, `l4_code` is the lowest-numbered one. Codes 5, 6, 7 and values above 13 are never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_vld | input | 1 | Header summary strobe, one cycle per packet |
| ip_ver | input | 4 | IP version field |
| ip_csum_ok | input | 1 | IPv4 header checksum passed |
| hop_lim | input | 8 | TTL or hop limit |
| ip_opt | input | 1 | IPv4 options or early IPv6 extension headers present |
| cap_len | input | LEN_W | Bytes captured, counted from the start of the IP header |
| ip_hdr_len | input | LEN_W | IP header length in bytes |
| ip_tot_len | input | LEN_W | IP total length in bytes, header included |
| l4_proto | input | 8 | L4 protocol number |
| l4_len | input | LEN_W | L4 length in bytes |
| src_port | input | 16 | L4 source port |
| dst_port | input | 16 | L4 destination port |
| tcp_flags | input | 8 | TCP flag byte |
| l4_csum_ok | input | 1 | L4 checksum passed |
| res_vld | output | 1 | Result valid pulse |
| ip_code | output | 3 | IP exception code |
| l4_code | output | 4 | L4 error code |

## Verification
A wrong priority encoder or a wrong gating term in this block shows up as a wrong code in the same result pulse. The error appears one cycle after the strobe that exposes it, because nothing is carried from one packet to the next. The risk is therefore in the coverage of inputs, not in the sequence. Each code is driven alone, several codes are made to compete to check the priority, and the gating cases are covered: an IP failure that suppresses L4, UDP carrying illegal flags, and protocols other than TCP and UDP. A broken valid register would show as a missing or extra pulse at the very next compare.

// File: rtl/hdr_exc_pkg.sv
// Shared code values and flag-bit positions for the header exception checker.
package hdr_exc_pkg;

    typedef enum logic [2:0] {
        IPX_NONE       = 3'd0,
        IPX_NOT_IP     = 3'd1,
        IPX_HDR_CSUM   = 3'd2,
        IPX_TRUNC_HDR  = 3'd3,
        IPX_TRUNC_BODY = 3'd4,
        IPX_HOP_ZERO   = 3'd5,
        IPX_OPTIONS    = 3'd6
    } ip_exc_e;

    typedef enum logic [3:0] {
        L4X_NONE      = 4'd0,
        L4X_SHORT     = 4'd1,
        L4X_CSUM      = 4'd2,
        L4X_LEN_MIS   = 4'd3,
        L4X_PORT_ZERO = 4'd4,
        L4X_FIN_ONLY  = 4'd8,
        L4X_NO_FLAGS  = 4'd9,
        L4X_FIN_RST   = 4'd10,
        L4X_SYN_URG   = 4'd11,
        L4X_SYN_RST   = 4'd12,
        L4X_SYN_FIN   = 4'd13
    } l4_exc_e;

    localparam int IP_HITS = 7;    // conditions indexed 0..6
    localparam int L4_HITS = 14;   // conditions indexed 0..13
    localparam int FLG_BASE = 8;   // first flag-derived L4 code

    localparam int FLG_FIN = 0;
    localparam int FLG_SYN = 1;
    localparam int FLG_RST = 2;
    localparam int FLG_URG = 5;

endpackage

// File: rtl/exc_prio_pick.sv
// Lowest-index priority pick over a hit vector.
// Bit 0 is unused: code 0 means "no hit". Returns the index of the
// lowest set bit among 1..N-1. Assumes N <= 2**W.
module exc_prio_pick #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] hit,
    output logic [W-1:0] code
);
    // scan from the top so the lowest set index is written last
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (hit[i]) code = W'(i);
        end
    end
endmodule

// File: rtl/ip_exc_classify.sv
// IP-level exception classification (combinational).
// Assumes lengths count bytes from the first byte of the IP header.
module ip_exc_classify
    import hdr_exc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [3:0]       ip_ver,
    input  logic             ip_csum_ok,
    input  logic [7:0]       hop_lim,
    input  logic             ip_opt,
    input  logic [LEN_W-1:0] cap_len,
    input  logic [LEN_W-1:0] ip_hdr_len,
    input  logic [LEN_W-1:0] ip_tot_len,
    output logic [2:0]       ip_code
);
    logic             is_v4;
    logic             is_v6;
    logic [IP_HITS-1:0] hit;

    // decode version and raise each independent IP condition
    always_comb begin
        is_v4 = (ip_ver == 4'd4);
        is_v6 = (ip_ver == 4'd6);
        hit   = '0;
        hit[IPX_NOT_IP]     = !is_v4 && !is_v6;
        hit[IPX_HDR_CSUM]   = is_v4 && !ip_csum_ok;
        hit[IPX_TRUNC_HDR]  = cap_len < ip_hdr_len;
        hit[IPX_TRUNC_BODY] = cap_len < ip_tot_len;
        hit[IPX_HOP_ZERO]   = (hop_lim == 8'd0);
        hit[IPX_OPTIONS]    = ip_opt;
    end

    exc_prio_pick #(.N(IP_HITS), .W(3)) u_pick (
        .hit  (hit),
        .code (ip_code)
    );
endmodule

// File: rtl/tcp_flag_classify.sv
// Flags illegal TCP flag combinations, one hit bit per code 8..13.
// Assumes the standard TCP flag byte bit order.
module tcp_flag_classify
    import hdr_exc_pkg::*;
(
    input  logic [7:0] flags,
    output logic [5:0] flag_hit
);
    logic fin, syn, rst, urg;

    // one hit per illegal pattern, bit k maps to code FLG_BASE + k
    always_comb begin
        fin = flags[FLG_FIN];
        syn = flags[FLG_SYN];
        rst = flags[FLG_RST];
        urg = flags[FLG_URG];
        flag_hit[0] = (flags[5:0] == 6'b000001);
        flag_hit[1] = (flags[5:0] == 6'b000000);
        flag_hit[2] = fin && rst;
        flag_hit[3] = syn && urg;
        flag_hit[4] = syn && rst;
        flag_hit[5] = syn && fin;
    end
endmodule

// File: rtl/l4_exc_classify.sv
// L4 error classification (combinational), gated by the IP result.
// Assumes cap_len and the IP lengths count from the IP header start.
module l4_exc_classify
    import hdr_exc_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int TCP_HDR   = 20,
    parameter int UDP_HDR   = 8,
    parameter int PROTO_TCP = 6,
    parameter int PROTO_UDP = 17,
    parameter bit FLAG_CHK  = 1'b1
) (
    input  logic [2:0]       ip_code,
    input  logic [7:0]       l4_proto,
    input  logic [LEN_W-1:0] cap_len,
    input  logic [LEN_W-1:0] ip_hdr_len,
    input  logic [LEN_W-1:0] ip_tot_len,
    input  logic [LEN_W-1:0] l4_len,
    input  logic [15:0]      src_port,
    input  logic [15:0]      dst_port,
    input  logic [7:0]       tcp_flags,
    input  logic             l4_csum_ok,
    output logic [3:0]       l4_code
);
    localparam int XW = LEN_W + 1;

    logic             is_tcp;
    logic             is_udp;
    logic             run_l4;
    logic [XW-1:0]    need_len;
    logic [LEN_W-1:0] ip_pay_len;
    logic [5:0]       flag_hit;
    logic [L4_HITS-1:0] hit;
    logic [3:0]       pick;

    generate
        if (FLAG_CHK) begin : g_flags
            tcp_flag_classify u_flags (
                .flags    (tcp_flags),
                .flag_hit (flag_hit)
            );
        end else begin : g_noflags
            assign flag_hit = '0;
        end
    endgenerate

    // protocol decode, gate and the length arithmetic
    always_comb begin
        is_tcp     = (l4_proto == 8'(PROTO_TCP));
        is_udp     = (l4_proto == 8'(PROTO_UDP));
        run_l4     = (is_tcp || is_udp) &&
                     (ip_code == IPX_NONE || ip_code == IPX_OPTIONS);
        need_len   = {1'b0, ip_hdr_len} +
                     (is_tcp ? XW'(TCP_HDR) : XW'(UDP_HDR));
        ip_pay_len = ip_tot_len - ip_hdr_len;
    end

    // collect the L4 conditions; codes 5..7 have no source
    always_comb begin
        hit = '0;
        hit[L4X_SHORT]     = {1'b0, cap_len} < need_len;
        hit[L4X_CSUM]      = !l4_csum_ok;
        hit[L4X_LEN_MIS]   = (l4_len != ip_pay_len);
        hit[L4X_PORT_ZERO] = (src_port == 16'd0) || (dst_port == 16'd0);
        for (int k = 0; k < 6; k++) begin
            hit[FLG_BASE + k] = is_tcp && flag_hit[k];
        end
    end

    exc_prio_pick #(.N(L4_HITS), .W(4)) u_pick (
        .hit  (hit),
        .code (pick)
    );

    // suppress the result when the L4 header is not to be trusted
    always_comb begin
        l4_code = run_l4 ? pick : 4'd0;
    end
endmodule

// File: rtl/hdr_exc_chk.sv
// Top: header exception checker. Classifies each strobed header summary
// and registers the IP and L4 codes with a one-cycle valid pulse.
// Assumes one summary per strobe; no back-pressure.
module hdr_exc_chk
    import hdr_exc_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int TCP_HDR   = 20,
    parameter int UDP_HDR   = 8,
    parameter int PROTO_TCP = 6,
    parameter int PROTO_UDP = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_vld,
    input  logic [3:0]       ip_ver,
    input  logic             ip_csum_ok,
    input  logic [7:0]       hop_lim,
    input  logic             ip_opt,
    input  logic [LEN_W-1:0] cap_len,
    input  logic [LEN_W-1:0] ip_hdr_len,
    input  logic [LEN_W-1:0] ip_tot_len,
    input  logic [7:0]       l4_proto,
    input  logic [LEN_W-1:0] l4_len,
    input  logic [15:0]      src_port,
    input  logic [15:0]      dst_port,
    input  logic [7:0]       tcp_flags,
    input  logic             l4_csum_ok,
    output logic             res_vld,
    output logic [2:0]       ip_code,
    output logic [3:0]       l4_code
);
    logic [2:0] ip_nxt;
    logic [3:0] l4_nxt;

    ip_exc_classify #(.LEN_W(LEN_W)) u_ip (
        .ip_ver     (ip_ver),
        .ip_csum_ok (ip_csum_ok),
        .hop_lim    (hop_lim),
        .ip_opt     (ip_opt),
        .cap_len    (cap_len),
        .ip_hdr_len (ip_hdr_len),
        .ip_tot_len (ip_tot_len),
        .ip_code    (ip_nxt)
    );

    l4_exc_classify #(
        .LEN_W     (LEN_W),
        .TCP_HDR   (TCP_HDR),
        .UDP_HDR   (UDP_HDR),
        .PROTO_TCP (PROTO_TCP),
        .PROTO_UDP (PROTO_UDP),
        .FLAG_CHK  (1'b1)
    ) u_l4 (
        .ip_code    (ip_nxt),
        .l4_proto   (l4_proto),
        .cap_len    (cap_len),
        .ip_hdr_len (ip_hdr_len),
        .ip_tot_len (ip_tot_len),
        .l4_len     (l4_len),
        .src_port   (src_port),
        .dst_port   (dst_port),
        .tcp_flags  (tcp_flags),
        .l4_csum_ok (l4_csum_ok),
        .l4_code    (l4_nxt)
    );

    // result register: codes held at zero between pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            ip_code <= 3'd0;
            l4_code <= 4'd0;
        end else begin
            res_vld <= sum_vld;
            ip_code <= sum_vld ? ip_nxt : 3'd0;
            l4_code <= sum_vld ? l4_nxt : 4'd0;
        end
    end
endmodule

// File: rtl/hdr_exc_chk_sva.sv
// Property checker for hdr_exc_chk, attached by bind.
module hdr_exc_chk_sva #(
    parameter int PROTO_TCP = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sum_vld,
    input logic [7:0] l4_proto,
    input logic       res_vld,
    input logic [2:0] ip_code,
    input logic [3:0] l4_code
);
    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |=> res_vld);
    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_vld |=> !res_vld);
    // R2
    idle_codes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (ip_code == 3'd0 && l4_code == 4'd0));
    // R10
    l4_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l4_code inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}));
    // R4
    ip_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_code != 3'd7);
    // R6
    l4_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l4_code != 4'd0) |-> (ip_code == 3'd0 || ip_code == 3'd6));
    // R9
    flag_code_tcp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && l4_code >= 4'd8) |-> ($past(l4_proto) == 8'(PROTO_TCP)));
endmodule

bind hdr_exc_chk hdr_exc_chk_sva #(.PROTO_TCP(PROTO_TCP)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .sum_vld  (sum_vld),
    .l4_proto (l4_proto),
    .res_vld  (res_vld),
    .ip_code  (ip_code),
    .l4_code  (l4_code)
);

// File: tb/hdr_exc_chk_tb_top.sv
// Scoreboard bench: driver pushes expected codes, monitor compares results.
module hdr_exc_chk_tb_top;
    localparam int LEN_W = 16;

    typedef struct {
        logic [3:0]       ver;
        logic             csok;
        logic [7:0]       hop;
        logic             opt;
        logic [LEN_W-1:0] cap;
        logic [LEN_W-1:0] hl;
        logic [LEN_W-1:0] tot;
        logic [7:0]       proto;
        logic [LEN_W-1:0] l4len;
        logic [15:0]      sp;
        logic [15:0]      dp;
        logic [7:0]       flg;
        logic             l4ok;
    } stim_t;

    typedef struct {
        logic [2:0] ip;
        logic [3:0] l4;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_vld = 1'b0;
    stim_t s;
    logic res_vld;
    logic [2:0] ip_code;
    logic [3:0] l4_code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    hdr_exc_chk dut_i (
        .clk(clk), .rst_n(rst_n), .sum_vld(sum_vld),
        .ip_ver(s.ver), .ip_csum_ok(s.csok), .hop_lim(s.hop), .ip_opt(s.opt),
        .cap_len(s.cap), .ip_hdr_len(s.hl), .ip_tot_len(s.tot),
        .l4_proto(s.proto), .l4_len(s.l4len), .src_port(s.sp), .dst_port(s.dp),
        .tcp_flags(s.flg), .l4_csum_ok(s.l4ok),
        .res_vld(res_vld), .ip_code(ip_code), .l4_code(l4_code)
    );

    function automatic stim_t clean_tcp();
        stim_t t;
        t.ver = 4'd4; t.csok = 1'b1; t.hop = 8'd64; t.opt = 1'b0;
        t.hl = 16'd20; t.tot = 16'd60; t.cap = 16'd60;
        t.proto = 8'd6; t.l4len = 16'd40; t.sp = 16'd1234; t.dp = 16'd80;
        t.flg = 8'h10; t.l4ok = 1'b1;
        return t;
    endfunction

    // expected codes written from the requirements
    function automatic exp_t model(stim_t t);
        exp_t e;
        logic tcp, udp;
        int hs;
        e.ip = 3'd0; e.l4 = 4'd0;
        if (t.ver != 4 && t.ver != 6) e.ip = 3'd1;
        else if (t.ver == 4 && !t.csok) e.ip = 3'd2;
        else if (t.cap < t.hl) e.ip = 3'd3;
        else if (t.cap < t.tot) e.ip = 3'd4;
        else if (t.hop == 0) e.ip = 3'd5;
        else if (t.opt) e.ip = 3'd6;
        tcp = (t.proto == 8'd6);
        udp = (t.proto == 8'd17);
        hs = tcp ? 20 : 8;
        if ((e.ip == 0 || e.ip == 6) && (tcp || udp)) begin
            if (int'(t.cap) < int'(t.hl) + hs) e.l4 = 4'd1;
            else if (!t.l4ok) e.l4 = 4'd2;
            else if (t.l4len != 16'(t.tot - t.hl)) e.l4 = 4'd3;
            else if (t.sp == 0 || t.dp == 0) e.l4 = 4'd4;
            else if (tcp) begin
                if (t.flg[5:0] == 6'h01) e.l4 = 4'd8;
                else if (t.flg[5:0] == 6'h00) e.l4 = 4'd9;
                else if (t.flg[0] && t.flg[2]) e.l4 = 4'd10;
                else if (t.flg[1] && t.flg[5]) e.l4 = 4'd11;
                else if (t.flg[1] && t.flg[2]) e.l4 = 4'd12;
                else if (t.flg[1] && t.flg[0]) e.l4 = 4'd13;
            end
        end
        return e;
    endfunction

    task automatic send(input stim_t t, input string req);
        exp_t e;
        @(negedge clk);
        s = t;
        sum_vld = 1'b1;
        e = model(t);
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        sum_vld = 1'b0;
    endtask

    // monitor: compare each result pulse with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected result pulse ip=%0d l4=%0d, expected none",
                         ip_code, l4_code);
            end else begin
                e = sb.pop_front();
                if (ip_code !== e.ip || l4_code !== e.l4) begin
                    fails++;
                    $display("FAIL %s: ip=%0d l4=%0d, expected ip=%0d l4=%0d",
                             e.req, ip_code, l4_code, e.ip, e.l4);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin : stimulus
        stim_t t;
        s = clean_tcp();
        s.flg = 8'h00;
        sum_vld = 1'b1;        // strobe held during reset must be dropped
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;              // R1: reset state
        if (res_vld !== 1'b0 || ip_code !== 3'd0 || l4_code !== 4'd0) begin
            fails++;
            $display("FAIL R1: vld=%0b ip=%0d l4=%0d, expected 0 0 0",
                     res_vld, ip_code, l4_code);
        end
        sum_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;              // R2: no pulse without strobe
        if (res_vld !== 1'b0) begin
            fails++;
            $display("FAIL R2: vld=%0b with no strobe, expected 0", res_vld);
        end

        send(clean_tcp(), "R2 clean TCP");
        t = clean_tcp(); t.proto = 8'd17; t.l4len = 16'd40; t.flg = 8'h00;
        send(t, "R9 clean UDP with zero flags");
        t = clean_tcp(); t.ver = 4'd5; send(t, "R3 not IP");
        t = clean_tcp(); t.csok = 1'b0; send(t, "R3 IPv4 header checksum");
        t = clean_tcp(); t.ver = 4'd6; t.csok = 1'b0; t.hl = 16'd40;
        t.tot = 16'd80; t.cap = 16'd80; send(t, "R3 IPv6 ignores checksum flag");
        t = clean_tcp(); t.cap = 16'd10; send(t, "R3 truncated header");
        t = clean_tcp(); t.cap = 16'd50; send(t, "R4 truncated body");
        t = clean_tcp(); t.hop = 8'd0; send(t, "R4 hop zero");
        t = clean_tcp(); t.opt = 1'b1; t.flg = 8'h01; send(t, "R4 options with L4 flags");
        t = clean_tcp(); t.csok = 1'b0; t.hop = 8'd0; t.opt = 1'b1;
        send(t, "R5 checksum beats hop and options");
        t = clean_tcp(); t.cap = 16'd30; t.tot = 16'd30; t.l4len = 16'd10;
        send(t, "R7 TCP too short");
        t = clean_tcp(); t.proto = 8'd17; t.cap = 16'd30; t.tot = 16'd30;
        t.l4len = 16'd10; send(t, "R7 UDP fits 8-byte header");
        t = clean_tcp(); t.l4ok = 1'b0; t.sp = 16'd0; send(t, "R10 checksum beats port zero");
        t = clean_tcp(); t.l4len = 16'd41; send(t, "R7 length mismatch");
        t = clean_tcp(); t.dp = 16'd0; t.flg = 8'h00; send(t, "R10 port zero beats flags");
        t = clean_tcp(); t.flg = 8'h01; send(t, "R8 FIN only");
        t = clean_tcp(); t.flg = 8'h00; send(t, "R8 no flags");
        t = clean_tcp(); t.flg = 8'h07; send(t, "R8 FIN RST SYN");
        t = clean_tcp(); t.flg = 8'h32; send(t, "R8 SYN URG");
        t = clean_tcp(); t.flg = 8'h16; send(t, "R8 SYN RST");
        t = clean_tcp(); t.flg = 8'h13; send(t, "R8 SYN FIN");
        t = clean_tcp(); t.proto = 8'd17; t.flg = 8'h03; send(t, "R9 UDP SYN FIN ignored");
        t = clean_tcp(); t.proto = 8'd1; t.l4ok = 1'b0; send(t, "R6 other protocol");
        t = clean_tcp(); t.hop = 8'd0; t.l4ok = 1'b0; send(t, "R6 IP error suppresses L4");

        // back-to-back strobes
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            t = clean_tcp();
            t.flg = (i % 2 == 0) ? 8'h01 : 8'h10;
            s = t;
            sum_vld = 1'b1;
            e = model(t);
            e.req = "R2 back-to-back";
            sb.push_back(e);
            @(negedge clk);
        end
        sum_vld = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule